// File: doc/BRIEF.md
# SPI Host Request Capture Engine

This block is the receive side of an SPI target that carries host commands. While the controller holds chip-select low, serial bits arrive in SPI mode 0, most significant bit first. The block packs them into bytes and stores them in a local byte buffer. The controller's chip-select and clock are asynchronous to the system clock, so the block samples them through a synchroniser. Completion is decided by the packet's own content, not by chip-select. A 16-bit little-endian length field sits at a programmable byte offset in the 8-byte request header. Once enough bytes have arrived to cover both a programmable minimum count and the header plus the announced payload, the block raises a sticky "length reached" status and gives a one-cycle verdict on the header.

The verdict accepts a request only when three conditions hold: the first byte is protocol version 3, header byte 5 (reserved) is zero, and the expected size fits in the buffer. The expected size is the header length plus the captured length. Firmware or a downstream engine then reads the stored bytes out as 32-bit words, lowest address in the least significant byte. When chip-select returns high, the block emits a one-cycle end-of-transfer pulse and clears the buffer for the next request.

The read port is a plain synchronous register-file port with no back-pressure. A word requested with `rd_en` appears on `rd_data` on the following cycle and holds until the next read. No valid/ready handshake applies, because the buffer cannot run dry underneath a read.

Top module: `spi_req_capture`

## Requirements
- R1: Bytes are assembled from MOSI sampled on SCLK rising edges, first bit as the most significant bit, and are stored at consecutive buffer addresses starting at 0. A read of word index k returns bytes 4k..4k+3 with byte 4k in bits [7:0].
- R2: While chip-select is high, the byte counter is held at zero and every buffer byte reads back as 0x00, so the next transfer stores its first byte at address 0.
- R3: Once the buffer holds BUF_BYTES bytes, further bytes of the same transfer are discarded and never overwrite stored bytes.
- R4: The data length is captured little-endian: the byte stored at address `cfg_len_offset` is the low byte and the byte at `cfg_len_offset`+1 is the high byte.
- R5: The length-reached event sets `vlen_status` only when both conditions hold: the stored byte count is at least `cfg_target_count`, and it is at least 8 plus the captured length. When 8 plus the length exceeds the buffer, the second condition is met at a full buffer. `cfg_target_count` must not exceed BUF_BYTES.
- R6: `vlen_status` is sticky until a `vlen_clr` pulse clears it, with a new event winning over a same-cycle clear. The event fires at most once per chip-select-low period, together with a single-cycle `verdict_valid`.
- R7: A request whose byte 0 differs from 0x03 is judged bad (`verdict_ok` = 0).
- R8: A request whose byte 5 is nonzero is judged bad.
- R9: `req_size` reports 8 plus the captured length. A request whose size is zero or exceeds BUF_BYTES is judged bad, and a request passing R7, R8 and this size test is judged good.
- R10: Each rising edge of chip-select produces exactly one `xfer_end` pulse, one clock cycle wide.
- R11: After reset, `vlen_status`, `verdict_valid`, `verdict_ok`, `req_size` and `xfer_end` are 0, and the buffer reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | SPI serial clock from the controller (asynchronous) |
| spi_mosi | input | 1 | SPI data from the controller |
| spi_cs_n | input | 1 | SPI chip-select, active low |
| cfg_len_offset | input | 16 | Byte address of the length field's low byte |
| cfg_target_count | input | 16 | Minimum stored bytes before the event may fire |
| vlen_clr | input | 1 | Write-one pulse that clears `vlen_status` |
| rd_en | input | 1 | Read request for the buffer |
| rd_addr | input | WORD_AW (4) | Word index to read |
| rd_data | output | 32 | Read word, valid the cycle after `rd_en` |
| vlen_status | output | 1 | Sticky length-reached status |
| verdict_valid | output | 1 | One-cycle pulse: header verdict available |
| verdict_ok | output | 1 | Header verdict, 1 = acceptable request |
| req_size | output | 17 | Expected request size in bytes |
| xfer_end | output | 1 | One-cycle pulse on chip-select rising |

## Verification
The assertions check several properties on every cycle:
- the byte counter never passes the buffer size;
- the counter and length state are cleared while chip-select is high;
- the event and the verdict are single-cycle and imply the sticky status;
- the status holds until cleared;
- an accepted verdict implies version 3 and a size within the buffer;
- the end pulse is one cycle wide.

Only the bench's scenarios can show the rest. That covers the contents that land in the buffer, and the bit order and word packing. It also covers the exact byte count at which the event fires against the target count and the length field, and whether the programmable offset really moves the captured length. It also shows that discarded bytes do not corrupt the stored ones.

// File: rtl/rqc_pkg.sv
package rqc_pkg;
  localparam int HDR_BYTES = 8;
  localparam logic [7:0] PROTO_VER = 8'h03;
  localparam int RSV_POS = 5;
  localparam int OFS_W = 16;
  localparam int SIZE_W = OFS_W + 1;
endpackage

// File: rtl/rqc_spi_front.sv
module rqc_spi_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       spi_sclk,
  input  logic       spi_mosi,
  input  logic       spi_cs_n,
  output logic       cs_idle,
  output logic       byte_stb,
  output logic [7:0] byte_data,
  output logic       xfer_end
);
  logic [SYNC_STAGES-1:0] sclk_q, mosi_q, cs_q;
  logic sclk_d, cs_d;
  logic [6:0] shreg;
  logic [2:0] bitcnt;
  logic sclk_rise, mosi_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= '0;
      mosi_q <= '0;
      cs_q   <= '1;
      sclk_d <= 1'b0;
      cs_d   <= 1'b1;
    end else begin
      sclk_q <= {sclk_q[SYNC_STAGES-2:0], spi_sclk};
      mosi_q <= {mosi_q[SYNC_STAGES-2:0], spi_mosi};
      cs_q   <= {cs_q[SYNC_STAGES-2:0], spi_cs_n};
      sclk_d <= sclk_q[SYNC_STAGES-1];
      cs_d   <= cs_q[SYNC_STAGES-1];
    end
  end

  assign cs_idle   = cs_q[SYNC_STAGES-1];
  assign sclk_rise = sclk_q[SYNC_STAGES-1] & ~sclk_d;
  assign mosi_s    = mosi_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg     <= '0;
      bitcnt    <= '0;
      byte_stb  <= 1'b0;
      byte_data <= '0;
      xfer_end  <= 1'b0;
    end else begin
      byte_stb <= 1'b0;
      xfer_end <= cs_idle & ~cs_d;
      if (cs_idle) begin
        bitcnt <= '0;
      end else if (sclk_rise) begin
        shreg  <= {shreg[5:0], mosi_s};
        bitcnt <= bitcnt + 3'd1;
        if (bitcnt == 3'd7) begin
          byte_stb  <= 1'b1;
          byte_data <= {shreg, mosi_s};
        end
      end
    end
  end

  assert_byte_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    byte_stb |=> !byte_stb);
  assert_end_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_end |=> !xfer_end);
endmodule

// File: rtl/rqc_rx_store.sv
module rqc_rx_store
  import rqc_pkg::*;
#(
  parameter int BUF_BYTES = 64,
  localparam int ADDR_W  = $clog2(BUF_BYTES),
  localparam int CNT_W   = $clog2(BUF_BYTES + 1),
  localparam int WORD_AW = ADDR_W - 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_idle,
  input  logic               byte_stb,
  input  logic [7:0]         byte_data,
  input  logic [OFS_W-1:0]   cfg_len_offset,
  input  logic [OFS_W-1:0]   cfg_target_count,
  input  logic               rd_en,
  input  logic [WORD_AW-1:0] rd_addr,
  output logic [31:0]        rd_data,
  output logic               hit,
  output logic [7:0]         hdr_ver,
  output logic [7:0]         hdr_rsv,
  output logic [OFS_W-1:0]   len_val
);
  logic [7:0] mem [BUF_BYTES];
  logic [CNT_W-1:0] cnt;
  logic [7:0] len_lo, len_hi;
  logic len_done, armed;
  logic [SIZE_W-1:0] cnt_x, need, thr;
  logic [31:0] rd_word;

  assign cnt_x   = SIZE_W'(cnt);
  assign len_val = {len_hi, len_lo};
  assign need    = SIZE_W'(HDR_BYTES) + SIZE_W'(len_val);
  assign thr     = (need > SIZE_W'(BUF_BYTES)) ? SIZE_W'(BUF_BYTES) : need;
  assign hit     = armed & len_done & (cnt_x >= SIZE_W'(cfg_target_count)) & (cnt_x >= thr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < BUF_BYTES; i++) mem[i] <= '0;
      cnt      <= '0;
      len_lo   <= '0;
      len_hi   <= '0;
      len_done <= 1'b0;
      armed    <= 1'b1;
    end else if (cs_idle) begin
      for (int i = 0; i < BUF_BYTES; i++) mem[i] <= '0;
      cnt      <= '0;
      len_lo   <= '0;
      len_hi   <= '0;
      len_done <= 1'b0;
      armed    <= 1'b1;
    end else begin
      if (hit) armed <= 1'b0;
      if (byte_stb && cnt < CNT_W'(BUF_BYTES)) begin
        mem[cnt[ADDR_W-1:0]] <= byte_data;
        cnt <= cnt + CNT_W'(1);
        if (cnt_x == SIZE_W'(cfg_len_offset)) len_lo <= byte_data;
        if (cnt_x == SIZE_W'(cfg_len_offset) + SIZE_W'(1)) begin
          len_hi   <= byte_data;
          len_done <= 1'b1;
        end
      end
    end
  end

  for (genvar k = 0; k < 4; k++) begin : g_lane
    assign rd_word[8*k +: 8] = mem[{rd_addr, 2'(k)}];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else if (rd_en) rd_data <= rd_word;
  end

  assign hdr_ver = mem[0];
  assign hdr_rsv = mem[RSV_POS];

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(BUF_BYTES));
  assert_clear_on_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_idle |=> (cnt == '0 && !len_done));
  assert_hit_once_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> !hit);
endmodule

// File: rtl/rqc_hdr_check.sv
module rqc_hdr_check
  import rqc_pkg::*;
#(
  parameter int BUF_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit,
  input  logic              vlen_clr,
  input  logic [7:0]        hdr_ver,
  input  logic [7:0]        hdr_rsv,
  input  logic [OFS_W-1:0]  len_val,
  output logic              vlen_status,
  output logic              verdict_valid,
  output logic              verdict_ok,
  output logic [SIZE_W-1:0] req_size
);
  logic [SIZE_W-1:0] size_now;
  logic good;

  assign size_now = SIZE_W'(HDR_BYTES) + SIZE_W'(len_val);
  assign good = (hdr_ver == PROTO_VER) && (hdr_rsv == 8'h00) &&
                (size_now != '0) && (size_now <= SIZE_W'(BUF_BYTES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vlen_status   <= 1'b0;
      verdict_valid <= 1'b0;
      verdict_ok    <= 1'b0;
      req_size      <= '0;
    end else begin
      verdict_valid <= hit;
      if (hit) begin
        vlen_status <= 1'b1;
        verdict_ok  <= good;
        req_size    <= size_now;
      end else if (vlen_clr) begin
        vlen_status <= 1'b0;
      end
    end
  end

  assert_status_on_verdict_R6: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_valid |-> vlen_status);
  assert_status_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (vlen_status && !vlen_clr) |=> vlen_status);
  assert_verdict_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_valid |=> !verdict_valid);
  assert_ok_version_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict_valid && verdict_ok) |-> $past(hdr_ver) == PROTO_VER);
  assert_ok_fits_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict_valid && verdict_ok) |-> req_size <= SIZE_W'(BUF_BYTES));
endmodule

// File: rtl/spi_req_capture.sv
module spi_req_capture
  import rqc_pkg::*;
#(
  parameter int BUF_BYTES   = 64,
  parameter int SYNC_STAGES = 2,
  localparam int WORD_AW    = $clog2(BUF_BYTES) - 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               spi_sclk,
  input  logic               spi_mosi,
  input  logic               spi_cs_n,
  input  logic [15:0]        cfg_len_offset,
  input  logic [15:0]        cfg_target_count,
  input  logic               vlen_clr,
  input  logic               rd_en,
  input  logic [WORD_AW-1:0] rd_addr,
  output logic [31:0]        rd_data,
  output logic               vlen_status,
  output logic               verdict_valid,
  output logic               verdict_ok,
  output logic [16:0]        req_size,
  output logic               xfer_end
);
  logic cs_idle, byte_stb, hit;
  logic [7:0] byte_data, hdr_ver, hdr_rsv;
  logic [OFS_W-1:0] len_val;

  rqc_spi_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .spi_cs_n(spi_cs_n), .cs_idle(cs_idle), .byte_stb(byte_stb),
    .byte_data(byte_data), .xfer_end(xfer_end)
  );

  rqc_rx_store #(.BUF_BYTES(BUF_BYTES)) u_store (
    .clk(clk), .rst_n(rst_n), .cs_idle(cs_idle), .byte_stb(byte_stb),
    .byte_data(byte_data), .cfg_len_offset(cfg_len_offset),
    .cfg_target_count(cfg_target_count), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .hit(hit), .hdr_ver(hdr_ver), .hdr_rsv(hdr_rsv),
    .len_val(len_val)
  );

  rqc_hdr_check #(.BUF_BYTES(BUF_BYTES)) u_check (
    .clk(clk), .rst_n(rst_n), .hit(hit), .vlen_clr(vlen_clr),
    .hdr_ver(hdr_ver), .hdr_rsv(hdr_rsv), .len_val(len_val),
    .vlen_status(vlen_status), .verdict_valid(verdict_valid),
    .verdict_ok(verdict_ok), .req_size(req_size)
  );
endmodule

// File: tb/test_spi_req_capture.sv
module test_spi_req_capture;
  typedef struct packed {
    logic [7:0]  ver;
    logic [7:0]  rsv;
    logic [15:0] len;
    logic [7:0]  nsend;
    logic        exp_v;
    logic        exp_ok;
    logic [16:0] exp_size;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{8'h03, 8'h00, 16'd4,     8'd12, 1'b1, 1'b1, 17'd12},
    '{8'h03, 8'h00, 16'd0,     8'd12, 1'b1, 1'b1, 17'd8},
    '{8'h02, 8'h00, 16'd4,     8'd12, 1'b1, 1'b0, 17'd12},
    '{8'h03, 8'h07, 16'd4,     8'd12, 1'b1, 1'b0, 17'd12},
    '{8'h03, 8'h00, 16'd20,    8'd28, 1'b1, 1'b1, 17'd28},
    '{8'h03, 8'h00, 16'd20,    8'd27, 1'b0, 1'b0, 17'd0},
    '{8'h03, 8'h00, 16'd100,   8'd70, 1'b1, 1'b0, 17'd108},
    '{8'h03, 8'h00, 16'd56,    8'd64, 1'b1, 1'b1, 17'd64},
    '{8'h03, 8'h00, 16'h0100,  8'd70, 1'b1, 1'b0, 17'd264}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic spi_sclk = 1'b0, spi_mosi = 1'b0, spi_cs_n = 1'b1;
  logic [15:0] cfg_len_offset = 16'd6, cfg_target_count = 16'd12;
  logic vlen_clr = 1'b0, rd_en = 1'b0;
  logic [3:0] rd_addr = '0;
  logic [31:0] rd_data;
  logic vlen_status, verdict_valid, verdict_ok, xfer_end;
  logic [16:0] req_size;
  int n_chk = 0, n_bad = 0, end_cnt = 0, verd_cnt = 0;
  bit done = 0;

  always #2 clk = ~clk;

  spi_req_capture i_spi_req_capture (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .spi_cs_n(spi_cs_n), .cfg_len_offset(cfg_len_offset),
    .cfg_target_count(cfg_target_count), .vlen_clr(vlen_clr), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data), .vlen_status(vlen_status),
    .verdict_valid(verdict_valid), .verdict_ok(verdict_ok),
    .req_size(req_size), .xfer_end(xfer_end)
  );

  always @(posedge clk) begin
    if (xfer_end) end_cnt <= end_cnt + 1;
    if (verdict_valid) verd_cnt <= verd_cnt + 1;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pkt_byte(int i, logic [7:0] ver, logic [7:0] rsv,
                                          logic [15:0] len, int ofs);
    if (i == 0) return ver;
    if (i == ofs) return len[7:0];
    if (i == ofs + 1) return len[15:8];
    if (i == 5) return rsv;
    if (i < 8) return 8'(8'h11 * i);
    return 8'(8'hA0 + i);
  endfunction

  function automatic logic [31:0] exp_word(int k, logic [7:0] ver, logic [7:0] rsv,
                                           logic [15:0] len, int ofs, int nsend);
    logic [31:0] w = '0;
    for (int j = 0; j < 4; j++)
      if (4*k + j < nsend && 4*k + j < 64) w[8*j +: 8] = pkt_byte(4*k + j, ver, rsv, len, ofs);
    return w;
  endfunction

  task automatic spi_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      spi_mosi = b[i];
      #16 spi_sclk = 1'b1;
      #16 spi_sclk = 1'b0;
    end
  endtask

  task automatic send_bytes(int from, int to, logic [7:0] ver, logic [7:0] rsv,
                            logic [15:0] len, int ofs);
    for (int i = from; i < to; i++) spi_byte(pkt_byte(i, ver, rsv, len, ofs));
    #56;
  endtask

  task automatic end_txn();
    #16 spi_cs_n = 1'b1;
    #64;
  endtask

  task automatic rd_word(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic pulse_clr();
    @(negedge clk); vlen_clr = 1'b1;
    @(negedge clk); vlen_clr = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int e0, v0;
    #20 rst_n = 1'b1;
    #20;
    @(negedge clk);
    // R11 reset state
    chk("R11 vlen_status", 32'(vlen_status), 32'd0);
    chk("R11 verdict_valid", 32'(verdict_valid), 32'd0);
    chk("R11 verdict_ok", 32'(verdict_ok), 32'd0);
    chk("R11 req_size", 32'(req_size), 32'd0);
    chk("R11 xfer_end", 32'(xfer_end), 32'd0);
    rd_word(4'd0, d);
    chk("R11 buffer", d, 32'd0);

    for (int v = 0; v < 9; v++) begin
      vec_t t = VECS[v];
      string okt;
      e0 = end_cnt; v0 = verd_cnt;
      okt = (t.ver != 8'h03) ? "R7 verdict" : (t.rsv != 8'h00) ? "R8 verdict" : "R9 verdict";
      spi_cs_n = 1'b0; #16;
      send_bytes(0, int'(t.nsend), t.ver, t.rsv, t.len, 6);
      chk("R5 vlen_status", 32'(vlen_status), 32'(t.exp_v));
      chk("R6 one verdict", 32'(verd_cnt - v0), 32'(t.exp_v));
      if (t.exp_v) begin
        chk(okt, 32'(verdict_ok), 32'(t.exp_ok));
        chk("R9 req_size", 32'(req_size), 32'(t.exp_size));
      end
      rd_word(4'd0, d);
      chk("R1 word0", d, exp_word(0, t.ver, t.rsv, t.len, 6, int'(t.nsend)));
      rd_word(4'd1, d);
      chk("R4 word1", d, exp_word(1, t.ver, t.rsv, t.len, 6, int'(t.nsend)));
      rd_word(4'd2, d);
      chk("R1 word2", d, exp_word(2, t.ver, t.rsv, t.len, 6, int'(t.nsend)));
      rd_word(4'd15, d);
      chk("R3 word15", d, exp_word(15, t.ver, t.rsv, t.len, 6, int'(t.nsend)));
      end_txn();
      chk("R10 end pulse", 32'(end_cnt - e0), 32'd1);
      rd_word(4'd0, d);
      chk("R2 cleared", d, 32'd0);
      pulse_clr();
      chk("R6 cleared", 32'(vlen_status), 32'd0);
    end

    // R4 programmable offset: length at bytes 2,3; bytes 6,7 carry 0xFFFF
    cfg_len_offset = 16'd2;
    spi_cs_n = 1'b0; #16;
    for (int i = 0; i < 12; i++) begin
      logic [7:0] b;
      b = (i == 0) ? 8'h03 : (i == 2) ? 8'h04 : (i == 6 || i == 7) ? 8'hFF :
          (i == 1 || i == 3 || i == 4 || i == 5) ? 8'h00 : 8'(8'hA0 + i);
      spi_byte(b);
    end
    #56;
    chk("R4 offset vlen", 32'(vlen_status), 32'd1);
    chk("R4 offset size", 32'(req_size), 32'd12);
    chk("R4 offset ok", 32'(verdict_ok), 32'd1);
    end_txn();
    pulse_clr();
    cfg_len_offset = 16'd6;

    // R5 target count dominates a short request
    cfg_target_count = 16'd20;
    spi_cs_n = 1'b0; #16;
    send_bytes(0, 19, 8'h03, 8'h00, 16'd0, 6);
    chk("R5 below target", 32'(vlen_status), 32'd0);
    send_bytes(19, 20, 8'h03, 8'h00, 16'd0, 6);
    chk("R5 at target", 32'(vlen_status), 32'd1);
    chk("R9 size", 32'(req_size), 32'd8);
    // R6 cleared mid-transfer stays clear while more bytes arrive
    pulse_clr();
    v0 = verd_cnt;
    send_bytes(20, 24, 8'h03, 8'h00, 16'd0, 6);
    chk("R6 no re-fire", 32'(vlen_status), 32'd0);
    chk("R6 no second verdict", 32'(verd_cnt - v0), 32'd0);
    e0 = end_cnt;
    end_txn();
    chk("R10 end pulse", 32'(end_cnt - e0), 32'd1);
    cfg_target_count = 16'd12;

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule